// File: doc/BRIEF.md
# Outbound Window Address Translator

This block converts local bus addresses into 64-bit remote addresses for transactions that the local side starts, whether writes or reads. One fixed 256 MB local window, from 0x6000_0000 to 0x6FFF_FFFF, is divided into 32 equal slots of 8 MB. Local address bits [27:23] pick the slot directly. Each slot has its own 64-bit remote base, written as two 32-bit halves, and an enable bit. The low 23 address bits pass through unchanged.

A lookup is a 32-bit address with a valid strobe. One clock later the block returns a valid flag, a hit flag, an error flag and the translated address. A small write port loads the slot table one half-base or control word at a time. Two neighbouring slots whose bases differ by exactly 8 MB behave as one continuous remote span. Software can use this to map a transfer larger than a single slot.

Top module: `oat_xlate`

## Requirements
- R1: After reset, `out_valid`, `out_hit`, `out_err` and `out_addr` are all zero, and every slot is disabled.
- R2: `out_valid` is high exactly one cycle after `in_valid` was high. While `out_valid` is low, the other outputs are zero.
- R3: A lookup hits only when `in_addr[31:28]` equals 4'h6. A miss gives `out_hit`=0, `out_err`=0 and `out_addr`=0.
- R4: For a hit, the slot index is `in_addr[27:23]`, so slot n begins at 0x6000_0000 + n*0x80_0000.
- R5: For a hit on an enabled slot, `out_addr` is {upper base[31:0], lower base[31:23], `in_addr[22:0]`}. Bits [22:0] of the programmed lower base have no effect.
- R6: A hit on a disabled slot gives `out_err`=1 and `out_addr`=0.
- R7: A `cfg_we` write to slot `cfg_region` uses the `cfg_field` code as follows. Code 0 loads the lower base from `cfg_wdata`. Code 1 loads the upper base. Code 2 loads the enable bit from `cfg_wdata[0]`. Code 3 changes nothing.
- R8: Reset clears both base halves of every slot to zero. A slot that is enabled with no base written translates to the offset alone.
- R9: A lookup in the same cycle as a table write to the same slot uses the table contents from before that write.
- R10: Slots n and n+1 with lower bases L and L+0x80_0000 and equal upper bases give one unbroken remote range across the slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_region | input | 5 | Slot addressed by the write |
| cfg_field | input | 2 | Word selected within the slot: 0 lower base, 1 upper base, 2 control, 3 none |
| cfg_wdata | input | 32 | Write data; bit 0 is the enable for the control word |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_hit | output | 1 | The address was inside the window |
| out_err | output | 1 | Hit on a disabled slot |
| out_addr | output | 64 | Translated remote address, zero unless hit and enabled |

## Verification
The checker assumes that reset is held for at least one clock before any lookup is checked. It also assumes that `in_valid` and `in_addr` are stable around each rising edge, because every property compares a lookup with the result on the next edge. The bench drives all inputs on the falling edge and holds the lookup strobe low during reset, so every checked lookup starts after reset ends. The random phase mixes window and non-window addresses with sparse table writes. Some of those writes land in the same cycle as a lookup, which covers the ordering case the properties do not state.

// File: rtl/oat_pkg.sv
package oat_pkg;

  // Word selector for the slot table write port
  typedef enum logic [1:0] {
    FLD_BASE_LO = 2'd0,
    FLD_BASE_HI = 2'd1,
    FLD_CTRL    = 2'd2,
    FLD_NONE    = 2'd3
  } cfg_field_e;

endpackage

// File: rtl/oat_sdp_ram.sv
// Simple dual-port memory: one write port, one registered read port,
// read-before-write on an address collision. No reset, so a block RAM fits.
module oat_sdp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/oat_window_decode.sv
// Splits a local address into window tag match, slot index and offset.
module oat_window_decode #(
  parameter int LA_W    = 32,
  parameter int SEL_LSB = 23,
  parameter int SEL_W   = 5,
  parameter logic [LA_W-1:0] WIN_BASE = 32'h6000_0000
) (
  input  logic [LA_W-1:0]    addr,
  output logic               hit,
  output logic [SEL_W-1:0]   region,
  output logic [SEL_LSB-1:0] offset
);

  localparam int TAG_LSB = SEL_LSB + SEL_W;
  localparam int TAG_W   = LA_W - TAG_LSB;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[LA_W-1:TAG_LSB];

  always_comb begin
    hit    = (addr[LA_W-1:TAG_LSB] == WIN_TAG);
    region = addr[TAG_LSB-1:SEL_LSB];
    offset = addr[SEL_LSB-1:0];
  end

endmodule

// File: rtl/oat_region_state.sv
// Per-slot enable and "half written" flags, kept in resettable flops so the
// base memories themselves never need a reset.
module oat_region_state
  import oat_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cfg_field_e       wr_field,
  input  logic             wr_enable_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_en,
  output logic             rd_lo_ok,
  output logic             rd_hi_ok
);

  logic [NREG-1:0] en_r;
  logic [NREG-1:0] lo_ok_r;
  logic [NREG-1:0] hi_ok_r;
  logic [NREG-1:0] wsel;

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wsel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r    <= '0;
      lo_ok_r <= '0;
      hi_ok_r <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wsel[r]) begin
          case (wr_field)
            FLD_BASE_LO: lo_ok_r[r] <= 1'b1;
            FLD_BASE_HI: hi_ok_r[r] <= 1'b1;
            FLD_CTRL:    en_r[r]    <= wr_enable_bit;
            default:     ;
          endcase
        end
      end
    end
  end

  // Registered read so it lines up with the memory read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en    <= 1'b0;
      rd_lo_ok <= 1'b0;
      rd_hi_ok <= 1'b0;
    end else begin
      rd_en    <= en_r[rd_idx];
      rd_lo_ok <= lo_ok_r[rd_idx];
      rd_hi_ok <= hi_ok_r[rd_idx];
    end
  end

endmodule

// File: rtl/oat_xlate.sv
// Outbound window address translator: top level.
module oat_xlate
  import oat_pkg::*;
#(
  parameter int LA_W    = 32,
  parameter int PA_W    = 64,
  parameter int SEL_LSB = 23,
  parameter int SEL_W   = 5,
  parameter logic [LA_W-1:0] WIN_BASE = 32'h6000_0000,
  localparam int NREG   = 1 << SEL_W,
  localparam int HI_W   = PA_W - LA_W,
  localparam int LO_W   = LA_W - SEL_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_region,
  input  logic [1:0]       cfg_field,
  input  logic [LA_W-1:0]  cfg_wdata,
  input  logic             in_valid,
  input  logic [LA_W-1:0]  in_addr,
  output logic             out_valid,
  output logic             out_hit,
  output logic             out_err,
  output logic [PA_W-1:0]  out_addr
);

  cfg_field_e fld;
  assign fld = cfg_field_e'(cfg_field);

  // Address split
  logic               dec_hit;
  logic [SEL_W-1:0]   dec_region;
  logic [SEL_LSB-1:0] dec_offset;

  oat_window_decode #(
    .LA_W    (LA_W),
    .SEL_LSB (SEL_LSB),
    .SEL_W   (SEL_W),
    .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr  (in_addr),
    .hit   (dec_hit),
    .region(dec_region),
    .offset(dec_offset)
  );

  // Base halves: only the bits above the slot boundary are stored for the low half
  logic [LO_W-1:0] lo_rd;
  logic [HI_W-1:0] hi_rd;

  oat_sdp_ram #(.W(LO_W), .DEPTH(NREG)) u_lo_ram (
    .clk  (clk),
    .we   (cfg_we && (fld == FLD_BASE_LO)),
    .waddr(cfg_region),
    .wdata(cfg_wdata[LA_W-1:SEL_LSB]),
    .raddr(dec_region),
    .rdata(lo_rd)
  );

  oat_sdp_ram #(.W(HI_W), .DEPTH(NREG)) u_hi_ram (
    .clk  (clk),
    .we   (cfg_we && (fld == FLD_BASE_HI)),
    .waddr(cfg_region),
    .wdata(cfg_wdata[HI_W-1:0]),
    .raddr(dec_region),
    .rdata(hi_rd)
  );

  logic st_en, st_lo_ok, st_hi_ok;

  oat_region_state #(.NREG(NREG)) u_state (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (cfg_we),
    .wr_idx       (cfg_region),
    .wr_field     (fld),
    .wr_enable_bit(cfg_wdata[0]),
    .rd_idx       (dec_region),
    .rd_en        (st_en),
    .rd_lo_ok     (st_lo_ok),
    .rd_hi_ok     (st_hi_ok)
  );

  // Lookup pipeline stage
  logic               v_q;
  logic               hit_q;
  logic [SEL_LSB-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      hit_q <= 1'b0;
      off_q <= '0;
    end else begin
      v_q   <= in_valid;
      hit_q <= in_valid && dec_hit;
      off_q <= dec_offset;
    end
  end

  // Result assembly
  logic            ok;
  logic [HI_W-1:0] hi_part;
  logic [LO_W-1:0] lo_part;

  always_comb begin
    out_valid = v_q;
    out_hit   = v_q && hit_q;
    ok        = out_hit && st_en;
    out_err   = out_hit && !st_en;
    hi_part   = st_hi_ok ? hi_rd : '0;
    lo_part   = st_lo_ok ? lo_rd : '0;
    out_addr  = ok ? {hi_part, lo_part, off_q} : '0;
  end

endmodule

// File: rtl/oat_xlate_chk.sv
module oat_xlate_chk #(
  parameter int PA_W  = 64,
  parameter int TAG_W = 4,
  parameter int OFF_W = 23,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'h6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [TAG_W-1:0] in_tag,
  input logic [OFF_W-1:0] in_off,
  input logic             out_valid,
  input logic             out_hit,
  input logic             out_err,
  input logic [PA_W-1:0]  out_addr
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_hit && !out_err && out_addr == '0));

  assert_outside_miss_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_tag != WIN_TAG) |=> !out_hit);

  assert_inside_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_tag == WIN_TAG) |=> out_hit);

  assert_miss_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (!out_err && out_addr == '0));

  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_tag == WIN_TAG) |=> (out_err || out_addr[OFF_W-1:0] == $past(in_off)));

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_hit && out_addr == '0));

endmodule

bind oat_xlate oat_xlate_chk #(
  .PA_W   (PA_W),
  .TAG_W  (LA_W - SEL_LSB - SEL_W),
  .OFF_W  (SEL_LSB),
  .WIN_TAG(WIN_BASE[LA_W-1:SEL_LSB+SEL_W])
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_tag   (in_addr[LA_W-1:SEL_LSB+SEL_W]),
  .in_off   (in_addr[SEL_LSB-1:0]),
  .out_valid(out_valid),
  .out_hit  (out_hit),
  .out_err  (out_err),
  .out_addr (out_addr)
);

// File: tb/oat_xlate_tb.sv
module oat_xlate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_region = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid, out_hit, out_err;
  logic [63:0] out_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  oat_xlate u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_err(out_err), .out_addr(out_addr)
  );

  // Behavioural reference state
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];
  bit          m_en [32];

  logic        exp_v = 1'b0, exp_hit = 1'b0, exp_err = 1'b0;
  logic [63:0] exp_addr = '0;
  string       ph = "R1";
  int          nchk = 0;
  int          nerr = 0;
  bit          done = 0;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", ph, what, act, exp);
    end
  endtask

  task automatic compare();
    check("valid", 64'(out_valid), 64'(exp_v));
    check("hit",   64'(out_hit),   64'(exp_hit));
    check("err",   64'(out_err),   64'(exp_err));
    check("addr",  out_addr,       exp_addr);
  endtask

  // One cycle: check last result, drive new inputs, predict, update table model
  task automatic step(input logic i_we, input logic [4:0] i_rg, input logic [1:0] i_fd,
                      input logic [31:0] i_wd, input logic i_v, input logic [31:0] i_a);
    int r;
    @(negedge clk);
    compare();
    cfg_we = i_we; cfg_region = i_rg; cfg_field = i_fd; cfg_wdata = i_wd;
    in_valid = i_v; in_addr = i_a;
    r = int'(i_a[27:23]);
    exp_v    = i_v;
    exp_hit  = i_v && (i_a[31:28] == 4'h6);
    exp_err  = exp_hit && !m_en[r];
    exp_addr = (exp_hit && m_en[r]) ? {m_hi[r], m_lo[r][31:23], i_a[22:0]} : 64'h0;
    if (i_we) begin
      case (i_fd)
        2'd0: m_lo[int'(i_rg)] = i_wd;
        2'd1: m_hi[int'(i_rg)] = i_wd;
        2'd2: m_en[int'(i_rg)] = i_wd[0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [4:0] rg, input logic [1:0] fd, input logic [31:0] wd);
    step(1'b1, rg, fd, wd, 1'b0, 32'h0);
  endtask

  task automatic look(input logic [31:0] a);
    step(1'b0, 5'd0, 2'd0, 32'h0, 1'b1, a);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_en[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state at the ports, then every slot reports disabled
    ph = "R1";
    check("valid", 64'(out_valid), 64'h0);
    check("hit",   64'(out_hit),   64'h0);
    check("err",   64'(out_err),   64'h0);
    check("addr",  out_addr,       64'h0);
    look(32'h6000_0000);
    look(32'h62AB_CDEF);
    look(32'h6FFF_FFFF);

    // R8: enable without base writes gives the bare offset
    ph = "R8";
    wr(5'd3, 2'd2, 32'h1);
    look(32'h6180_1234);

    // R5: base substitution; low base bits below the boundary ignored
    ph = "R5";
    wr(5'd0, 2'd0, 32'h9000_0000);
    wr(5'd0, 2'd2, 32'h1);
    look(32'h6001_5678);
    wr(5'd0, 2'd0, 32'h9012_3456);
    look(32'h6001_5678);
    wr(5'd0, 2'd0, 32'h9000_0000);

    // R10 and R4: slots 18 and 19 chained into one remote span
    ph = "R10";
    wr(5'd18, 2'd1, 32'h1234_5678);
    wr(5'd18, 2'd0, 32'h7000_0000);
    wr(5'd19, 2'd1, 32'h1234_5678);
    wr(5'd19, 2'd0, 32'h7080_0000);
    wr(5'd18, 2'd2, 32'h1);
    wr(5'd19, 2'd2, 32'h1);
    look(32'h6900_0000);
    look(32'h697F_FFFC);
    look(32'h6980_0000);
    look(32'h69BF_FFFF);
    ph = "R4";
    look(32'h6A00_0000);   // slot 20, still disabled

    // R3: addresses outside the window
    ph = "R3";
    look(32'h5FFF_FFFF);
    look(32'h7000_0000);
    look(32'h0000_0000);
    look(32'hFFFF_FFFF);

    // R7: code 3 changes nothing; clearing the enable causes an error
    ph = "R7";
    wr(5'd18, 2'd3, 32'hFFFF_FFFF);
    look(32'h6900_0040);
    wr(5'd19, 2'd2, 32'h0);
    look(32'h6980_0000);

    // R9: write and lookup on the same slot in the same cycle
    ph = "R9";
    step(1'b1, 5'd0, 2'd0, 32'hA000_0000, 1'b1, 32'h6000_0010);
    look(32'h6000_0010);
    step(1'b1, 5'd0, 2'd2, 32'h0, 1'b1, 32'h6000_0020);
    look(32'h6000_0020);

    // R2 with random traffic, table writes and idle cycles
    ph = "R2";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic        w;
      a = $urandom();
      if ($urandom_range(0, 3) != 0) a[31:28] = 4'h6;
      w = ($urandom_range(0, 7) == 0);
      step(w, 5'($urandom()), 2'($urandom()), $urandom(),
           ($urandom_range(0, 4) != 0), a);
    end
    step(1'b0, 5'd0, 2'd0, 32'h0, 1'b0, 32'h0);
    @(negedge clk);
    compare();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule